// File: doc/BRIEF.md
# Zeroing-Idiom Aware Issue Scoreboard

This block decides, one decoded instruction per cycle, whether that instruction may issue in order or has to stall. It keeps a result countdown for every architectural register in three classes: general, 64-bit packed-integer and 128-bit vector. An instruction issues once each source it really depends on has a countdown of zero. A stalled instruction stays at the input until it issues. The block also reports how many execution units the issued instruction takes. Two running counters, one for issued instructions and one for stall cycles, let a test compare a loop that is bound by latency with a control loop.

An exclusive-or whose two sources name the same register always produces zero, whatever the old value was. The block flags this pattern. A two-bit mode then decides how it is handled. In the legacy modes the pattern still waits for the old value. In the execute mode it waits for nothing on the general and vector classes, but it still takes execution units, and it still waits on the packed-integer class. In the rename mode it waits for nothing on any class and takes no unit.

Independently of the mode, a per-register known-zero-upper flag on the general class removes the merge penalty that a low-part write followed by a full-width read would otherwise cost.

Top module: `zidiom_scoreboard`

## Requirements
- R1: `zero_idiom` is high exactly when `in_valid` is high, `in_kind` is 1 (exclusive-or) and `in_src1` equals `in_src2`, in every mode and class.
- R2: A consumer of a result issues exactly L cycles after its producer issues, and stalls in every cycle before that. L is 4 for a multiply (kind 2) on the general (class 0, and class 3, which is treated as general) or vector (class 2) class, 3 for a multiply on the packed-integer class (class 1), and 1 for copy, exclusive-or and low-part writes. Copy (kind 0) reads `in_src1`. Exclusive-or and multiply read both sources. Low-part writes (kinds 3 and 4) and no-ops (kinds 5 to 7) read nothing.
- R3: In modes 0 and 3 (legacy), a zeroing exclusive-or waits for its source like any other exclusive-or.
- R4: In mode 1 (execute), a zeroing exclusive-or on the general or vector class issues without waiting for its source. On the packed-integer class it still waits.
- R5: In mode 2 (rename), a zeroing exclusive-or on any class issues without waiting, reports `exec_slots` 0, and a consumer of its destination can issue in the very next cycle.
- R6: `exec_slots` is 0 when nothing issues, and also for an issued no-op or an op removed in rename. Otherwise it is 2 for a vector-class op and 1 for any other op.
- R7: On the general class, a low-byte (kind 3) or low-halfword (kind 4) write to a register whose known-zero-upper flag is clear, followed by a full-width read of that register, stalls the reader for MERGE_PEN+1 cycles beyond any result wait.
- R8: The known-zero-upper flag is set by a zeroing exclusive-or on a general register in any mode. Low-part writes keep it. Any other full-width write clears it. While it is set, a low-part write followed by a full read costs no merge stall.
- R9: `stall` is high exactly when `in_valid` is high and `issue` is low. A stalled instruction changes no register state except that its merges start.
- R10: `issued_cnt` increments on each cycle with `issue` high, and `stall_cnt` increments on each cycle with `stall` high.
- R11: After reset all registers are ready, all known-zero and merge flags are clear, and both counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A decoded instruction is present |
| in_class | input | 2 | Register class: 0 general, 1 packed-integer, 2 vector, 3 treated as general |
| in_kind | input | 3 | 0 copy, 1 exclusive-or, 2 multiply, 3 low-byte write, 4 low-halfword write, 5-7 no-op |
| in_dst | input | IDXW | Destination register index |
| in_src1 | input | IDXW | First source register index |
| in_src2 | input | IDXW | Second source register index |
| mode | input | 2 | 0 legacy, 1 execute, 2 rename, 3 legacy |
| issue | output | 1 | The instruction issues this cycle |
| stall | output | 1 | The instruction is held this cycle |
| exec_slots | output | 2 | Execution units taken by the issuing instruction |
| zero_idiom | output | 1 | Same-register exclusive-or recognised |
| issued_cnt | output | CNTW | Issued-instruction count |
| stall_cnt | output | CNTW | Stall-cycle count |

## Verification
The main test is a loop that alternates a zeroing exclusive-or with a multiply that reads its result. It runs in each mode and on each class. The stall counts separate a chain that is bound by latency (3 stalls per pair on the general class, 2 on packed-integer) from one where the false dependency is broken (none). Low-part write sequences with and without a preceding zeroing exclusive-or separate a merge stall from a clean read, and a multiply placed in between shows that the known-zero flag is cleared. A reference model running in step compares every output in every cycle, so slot usage and the pattern flag are checked for every instruction in the stream.

// File: rtl/zsb_pkg.sv
package zsb_pkg;
   localparam int NCLS = 3;

   typedef enum logic [1:0] {
      CL_GEN = 2'd0,
      CL_PKI = 2'd1,
      CL_VEC = 2'd2,
      CL_ALT = 2'd3
   } rclass_e;

   typedef enum logic [2:0] {
      K_MOVE = 3'd0,
      K_XOR  = 3'd1,
      K_MUL  = 3'd2,
      K_LO8  = 3'd3,
      K_LO16 = 3'd4,
      K_NOPA = 3'd5,
      K_NOPB = 3'd6,
      K_NOPC = 3'd7
   } okind_e;

   typedef enum logic [1:0] {
      M_LEGACY = 2'd0,
      M_EXEC   = 2'd1,
      M_RENAME = 2'd2,
      M_RSVD   = 2'd3
   } zmode_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/zsb_decode.sv
module zsb_decode
   import zsb_pkg::*;
#(
   parameter int IDXW        = 3,
   parameter int CDW         = 3,
   parameter int LAT_ALU     = 1,
   parameter int LAT_MUL_GEN = 4,
   parameter int LAT_MUL_PKI = 3,
   parameter int LAT_MUL_VEC = 4
) (
   input  logic            valid,
   input  logic [1:0]      cls_raw,
   input  logic [2:0]      kind_raw,
   input  logic [1:0]      mode_raw,
   input  logic [IDXW-1:0] src1,
   input  logic [IDXW-1:0] src2,
   output logic [1:0]      cls,
   output logic            idiom,
   output logic            need1,
   output logic            need2,
   output logic            wr_dst,
   output logic            wr_part,
   output logic            same_zero,
   output logic [CDW-1:0]  cd_load,
   output logic [1:0]      slots
);
   okind_e  k;
   zmode_e  m;
   rclass_e c;
   logic    brk, elim;

   always_comb begin
      k         = okind_e'(kind_raw);
      m         = zmode_e'(mode_raw);
      c         = (rclass_e'(cls_raw) == CL_ALT) ? CL_GEN : rclass_e'(cls_raw);
      cls       = c;
      same_zero = (k == K_XOR) && (src1 == src2);
      idiom     = valid && same_zero;
      brk       = same_zero && ((m == M_RENAME) || ((m == M_EXEC) && (c != CL_PKI)));
      elim      = same_zero && (m == M_RENAME);
      need1     = ((k == K_MOVE) || (k == K_XOR) || (k == K_MUL)) && !brk;
      need2     = ((k == K_XOR) || (k == K_MUL)) && !brk;
      wr_dst    = (kind_raw <= 3'd4);
      wr_part   = ((k == K_LO8) || (k == K_LO16)) && (c == CL_GEN);
      if (elim)
         cd_load = '0;
      else if (k == K_MUL)
         case (c)
            CL_PKI:  cd_load = CDW'(LAT_MUL_PKI - 1);
            CL_VEC:  cd_load = CDW'(LAT_MUL_VEC - 1);
            default: cd_load = CDW'(LAT_MUL_GEN - 1);
         endcase
      else
         cd_load = CDW'(LAT_ALU - 1);
      if (!wr_dst || elim)
         slots = 2'd0;
      else if (c == CL_VEC)
         slots = 2'd2;
      else
         slots = 2'd1;
   end
endmodule

// File: rtl/zsb_busy_bank.sv
module zsb_busy_bank #(
   parameter int NREG = 8,
   parameter int CDW  = 3,
   parameter int MRG  = 3,
   localparam int IDXW = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [IDXW-1:0] wr_idx,
   input  logic [CDW-1:0]  wr_val,
   input  logic [NREG-1:0] mrg_vec,
   output logic [NREG-1:0] rdy_vec
);
   for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic [CDW-1:0] cd_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            cd_q <= '0;
         else if (wr_en && (wr_idx == IDXW'(r)))
            cd_q <= wr_val;
         else if (mrg_vec[r])
            cd_q <= CDW'(MRG);
         else if (cd_q != '0)
            cd_q <= cd_q - 1'b1;
      end
      assign rdy_vec[r] = (cd_q == '0);
   end
endmodule

// File: rtl/zsb_zero_flags.sv
module zsb_zero_flags #(
   parameter int NREG = 8,
   localparam int IDXW = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            upd_en,
   input  logic [IDXW-1:0] upd_idx,
   input  logic            upd_idiom,
   input  logic            upd_part,
   input  logic [NREG-1:0] clr_vec,
   output logic [NREG-1:0] dirty_vec
);
   for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic kzu_q, dirty_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            kzu_q   <= 1'b0;
            dirty_q <= 1'b0;
         end else if (upd_en && (upd_idx == IDXW'(r))) begin
            if (upd_idiom) begin
               kzu_q   <= 1'b1;
               dirty_q <= 1'b0;
            end else if (upd_part) begin
               dirty_q <= !kzu_q;
            end else begin
               kzu_q   <= 1'b0;
               dirty_q <= 1'b0;
            end
         end else if (clr_vec[r]) begin
            dirty_q <= 1'b0;
         end
      end
      assign dirty_vec[r] = dirty_q;
   end
endmodule

// File: rtl/zidiom_scoreboard.sv
module zidiom_scoreboard
   import zsb_pkg::*;
#(
   parameter int NREG        = 8,
   parameter int CNTW        = 32,
   parameter int LAT_ALU     = 1,
   parameter int LAT_MUL_GEN = 4,
   parameter int LAT_MUL_PKI = 3,
   parameter int LAT_MUL_VEC = 4,
   parameter int MERGE_PEN   = 3,
   localparam int IDXW  = $clog2(NREG),
   localparam int MAXCD = imax(imax(LAT_MUL_GEN, LAT_MUL_PKI), imax(LAT_MUL_VEC, LAT_ALU)),
   localparam int CDW   = $clog2(imax(MAXCD, MERGE_PEN) + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [1:0]      in_class,
   input  logic [2:0]      in_kind,
   input  logic [IDXW-1:0] in_dst,
   input  logic [IDXW-1:0] in_src1,
   input  logic [IDXW-1:0] in_src2,
   input  logic [1:0]      mode,
   output logic            issue,
   output logic            stall,
   output logic [1:0]      exec_slots,
   output logic            zero_idiom,
   output logic [CNTW-1:0] issued_cnt,
   output logic [CNTW-1:0] stall_cnt
);
   if (NREG < 2) begin : g_bad_nreg
      $error("NREG must be at least 2");
   end
   if (LAT_ALU < 1 || LAT_MUL_GEN < 1 || LAT_MUL_PKI < 1 || LAT_MUL_VEC < 1) begin : g_bad_lat
      $error("latencies must be at least 1");
   end
   if (MERGE_PEN < 1) begin : g_bad_mrg
      $error("MERGE_PEN must be at least 1");
   end

   logic [1:0]     cls;
   logic           need1, need2, wr_dst, wr_part, same_zero;
   logic [CDW-1:0] cd_load;
   logic [1:0]     slots;
   logic [NCLS-1:0][NREG-1:0] rdy_m;
   logic [NREG-1:0] dirty_vec, mrg_gen;
   logic           ok1, ok2, is_gen;

   zsb_decode #(
      .IDXW(IDXW), .CDW(CDW), .LAT_ALU(LAT_ALU), .LAT_MUL_GEN(LAT_MUL_GEN),
      .LAT_MUL_PKI(LAT_MUL_PKI), .LAT_MUL_VEC(LAT_MUL_VEC)
   ) u_dec (
      .valid(in_valid), .cls_raw(in_class), .kind_raw(in_kind), .mode_raw(mode),
      .src1(in_src1), .src2(in_src2), .cls(cls), .idiom(zero_idiom),
      .need1(need1), .need2(need2), .wr_dst(wr_dst), .wr_part(wr_part),
      .same_zero(same_zero), .cd_load(cd_load), .slots(slots)
   );

   assign is_gen = (cls == CL_GEN);
   assign ok1    = !need1 || (rdy_m[cls][in_src1] && !(is_gen && dirty_vec[in_src1]));
   assign ok2    = !need2 || (rdy_m[cls][in_src2] && !(is_gen && dirty_vec[in_src2]));
   assign issue  = in_valid && ok1 && ok2;
   assign stall  = in_valid && !issue;
   assign exec_slots = issue ? slots : 2'd0;

   for (genvar r = 0; r < NREG; r++) begin : g_mrg
      assign mrg_gen[r] = stall && is_gen && dirty_vec[r] && rdy_m[CL_GEN][r] &&
                          ((need1 && (in_src1 == IDXW'(r))) || (need2 && (in_src2 == IDXW'(r))));
   end

   for (genvar c = 0; c < NCLS; c++) begin : g_bank
      logic [NREG-1:0] mv;
      if (c == 0) begin : g_gen
         assign mv = mrg_gen;
      end else begin : g_oth
         assign mv = '0;
      end
      zsb_busy_bank #(.NREG(NREG), .CDW(CDW), .MRG(MERGE_PEN)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .wr_en(issue && wr_dst && (cls == 2'(c))),
         .wr_idx(in_dst), .wr_val(cd_load), .mrg_vec(mv), .rdy_vec(rdy_m[c])
      );
   end

   zsb_zero_flags #(.NREG(NREG)) u_flags (
      .clk(clk), .rst_n(rst_n),
      .upd_en(issue && wr_dst && is_gen), .upd_idx(in_dst),
      .upd_idiom(same_zero), .upd_part(wr_part),
      .clr_vec(mrg_gen), .dirty_vec(dirty_vec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         issued_cnt <= '0;
         stall_cnt  <= '0;
      end else begin
         if (issue) issued_cnt <= issued_cnt + 1'b1;
         if (stall) stall_cnt  <= stall_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/zsb_scoreboard_chk.sv
module zsb_scoreboard_chk #(
   parameter int NREG = 8,
   parameter int CNTW = 32,
   localparam int IDXW = $clog2(NREG)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [1:0]      in_class,
   input logic [2:0]      in_kind,
   input logic [IDXW-1:0] in_src1,
   input logic [IDXW-1:0] in_src2,
   input logic [1:0]      mode,
   input logic            issue,
   input logic            stall,
   input logic [1:0]      exec_slots,
   input logic            zero_idiom,
   input logic [CNTW-1:0] issued_cnt,
   input logic [CNTW-1:0] stall_cnt
);
   a_r1_idiom_seen: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_kind == 3'd1 && in_src1 == in_src2) |-> zero_idiom);
   a_r1_idiom_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> !zero_idiom);
   a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(issue && stall));
   a_r9_decided: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (issue || stall));
   a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> (!issue && !stall));
   a_r6_no_slots_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |-> (exec_slots == 2'd0));
   a_r6_vec_mul_two: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && in_class == 2'd2 && in_kind == 3'd2) |-> (exec_slots == 2'd2));
   a_r5_elim_free: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == 2'd2 && in_kind == 3'd1 && in_src1 == in_src2) |->
      (issue && exec_slots == 2'd0));
   a_r10_issue_count: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> (issued_cnt == $past(issued_cnt) + CNTW'(1)));
   a_r10_stall_count: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> (stall_cnt == $past(stall_cnt) + CNTW'(1)));
   a_r10_issue_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |=> $stable(issued_cnt));
endmodule

bind zidiom_scoreboard zsb_scoreboard_chk #(.NREG(NREG), .CNTW(CNTW)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
   .in_kind(in_kind), .in_src1(in_src1), .in_src2(in_src2), .mode(mode),
   .issue(issue), .stall(stall), .exec_slots(exec_slots), .zero_idiom(zero_idiom),
   .issued_cnt(issued_cnt), .stall_cnt(stall_cnt)
);

// File: tb/zidiom_scoreboard_tb_top.sv
module zidiom_scoreboard_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NREG = 8;
   localparam int IDXW = 3;
   localparam int CNTW = 32;
   localparam int MPEN = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [1:0]      in_class = '0;
   logic [2:0]      in_kind = '0;
   logic [IDXW-1:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
   logic [1:0]      mode = '0;
   logic            issue, stall, zero_idiom;
   logic [1:0]      exec_slots;
   logic [CNTW-1:0] issued_cnt, stall_cnt;

   zidiom_scoreboard #(.NREG(NREG), .CNTW(CNTW), .MERGE_PEN(MPEN)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
      .in_kind(in_kind), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
      .mode(mode), .issue(issue), .stall(stall), .exec_slots(exec_slots),
      .zero_idiom(zero_idiom), .issued_cnt(issued_cnt), .stall_cnt(stall_cnt)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, errors = 0;
   int mb[3][NREG];
   bit mk[NREG], md[NREG];
   int m_iss = 0, m_stl = 0;
   bit done = 1'b0;

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic run_op(int mo, int cl, int kd, int d, int s1, int s2);
      int tries = 0;
      forever begin
         int c, es, lat;
         bit idi, brk, elim, n1, n2, ok1, ok2, ei, wr, mg1, mg2;
         @(negedge clk);
         in_valid = 1'b1; mode = 2'(mo); in_class = 2'(cl); in_kind = 3'(kd);
         in_dst = IDXW'(d); in_src1 = IDXW'(s1); in_src2 = IDXW'(s2);
         #1;
         c    = (cl == 3) ? 0 : cl;
         idi  = (kd == 1) && (s1 == s2);
         brk  = idi && ((mo == 2) || ((mo == 1) && (c != 1)));
         elim = idi && (mo == 2);
         n1   = (kd <= 2) && !brk;
         n2   = ((kd == 1) || (kd == 2)) && !brk;
         ok1  = !n1 || ((mb[c][s1] == 0) && !((c == 0) && md[s1]));
         ok2  = !n2 || ((mb[c][s2] == 0) && !((c == 0) && md[s2]));
         ei   = ok1 && ok2;
         wr   = (kd <= 4);
         es   = (!ei || !wr || elim) ? 0 : ((c == 2) ? 2 : 1);
         chk("R2", "issue", int'(issue), int'(ei));
         chk("R9", "stall", int'(stall), int'(!ei));
         chk("R6", "exec_slots", int'(exec_slots), es);
         chk("R1", "zero_idiom", int'(zero_idiom), int'(idi));
         chk("R10", "issued_cnt", int'(issued_cnt), m_iss);
         chk("R10", "stall_cnt", int'(stall_cnt), m_stl);
         mg1 = !ei && (c == 0) && n1 && md[s1] && (mb[0][s1] == 0);
         mg2 = !ei && (c == 0) && n2 && md[s2] && (mb[0][s2] == 0);
         @(posedge clk);
         for (int q = 0; q < 3; q++)
            for (int r = 0; r < NREG; r++)
               if (mb[q][r] > 0) mb[q][r]--;
         if (ei) begin
            m_iss++;
            if (wr) begin
               lat = (kd == 2) ? ((c == 1) ? 3 : 4) : 1;
               mb[c][d] = elim ? 0 : lat - 1;
               if (c == 0) begin
                  if (idi) begin mk[d] = 1; md[d] = 0; end
                  else if (kd >= 3) md[d] = !mk[d];
                  else begin mk[d] = 0; md[d] = 0; end
               end
            end
            break;
         end else begin
            m_stl++;
            if (mg1) begin mb[0][s1] = MPEN; md[s1] = 0; end
            if (mg2) begin mb[0][s2] = MPEN; md[s2] = 0; end
         end
         tries++;
         if (tries > 60) begin
            chk("R9", "hung instruction", 0, 1);
            break;
         end
      end
   endtask

   task automatic drain();
      for (int i = 0; i < 6; i++) run_op(0, 0, 5, 0, 0, 0);
   endtask

   task automatic chain(int mo, int cl, int d, int n);
      for (int i = 0; i < n; i++) begin
         run_op(mo, cl, 1, d, d, d);
         run_op(mo, cl, 2, d, d, d);
      end
   endtask

   function automatic int stalls_now();
      return int'(stall_cnt);
   endfunction

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int s0;
      for (int q = 0; q < 3; q++)
         for (int r = 0; r < NREG; r++) mb[q][r] = 0;
      for (int r = 0; r < NREG; r++) begin mk[r] = 0; md[r] = 0; end
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R11", "reset issue", int'(issue), 0);
      chk("R11", "reset stall", int'(stall), 0);
      chk("R11", "reset issued_cnt", int'(issued_cnt), 0);
      chk("R11", "reset stall_cnt", int'(stall_cnt), 0);

      // R3 legacy chain on general class: 3 stalls per pair after the first
      #1 s0 = stalls_now(); chain(0, 0, 0, 10); #1;
      chk("R3", "legacy general chain stalls", stalls_now() - s0, 27);
      drain();
      // R4 execute mode, general class: dependency broken
      #1 s0 = stalls_now(); chain(1, 0, 0, 10); #1;
      chk("R4", "execute general chain stalls", stalls_now() - s0, 0);
      drain();
      // R4 execute mode, packed-integer class: still waits (multiply latency 3)
      #1 s0 = stalls_now(); chain(1, 1, 2, 10); #1;
      chk("R4", "execute packed chain stalls", stalls_now() - s0, 18);
      drain();
      // R4 execute mode, vector class: broken, two slots per op
      #1 s0 = stalls_now(); chain(1, 2, 4, 10); #1;
      chk("R4", "execute vector chain stalls", stalls_now() - s0, 0);
      drain();
      // R5 rename mode, packed-integer class: broken and free
      #1 s0 = stalls_now(); chain(2, 1, 5, 10); #1;
      chk("R5", "rename packed chain stalls", stalls_now() - s0, 0);
      drain();
      // R3 mode 3 behaves as legacy, class 3 as general
      #1 s0 = stalls_now(); chain(3, 3, 6, 3); #1;
      chk("R3", "mode 3 chain stalls", stalls_now() - s0, 6);
      drain();
      // R2 vector multiply to copy: latency 4
      #1 s0 = stalls_now();
      run_op(1, 2, 2, 1, 2, 2); run_op(1, 2, 0, 3, 1, 0); #1;
      chk("R2", "vector multiply consumer stalls", stalls_now() - s0, 3);
      drain();
      // R7 low-byte write without known zero, then full read
      #1 s0 = stalls_now();
      run_op(0, 0, 3, 1, 0, 0); run_op(0, 0, 0, 2, 1, 1); #1;
      chk("R7", "merge stall cycles", stalls_now() - s0, MPEN + 1);
      drain();
      // R8 known zero after idiom, kept across two low-part writes
      #1 s0 = stalls_now();
      run_op(0, 0, 1, 3, 3, 3); run_op(0, 0, 3, 3, 0, 0);
      run_op(0, 0, 4, 3, 0, 0); run_op(0, 0, 0, 4, 3, 3); #1;
      chk("R8", "no merge after idiom", stalls_now() - s0, 0);
      // R8 multiply clears the flag; merge stall returns
      #1 s0 = stalls_now();
      run_op(0, 0, 2, 3, 3, 3); run_op(0, 0, 3, 3, 0, 0);
      run_op(0, 0, 0, 5, 3, 3); #1;
      chk("R8", "merge after cleared flag", stalls_now() - s0, MPEN + 1);
      drain();
      // R6 non-idiom exclusive-or in rename mode still takes a slot and waits
      run_op(2, 0, 2, 6, 1, 1);
      #1 s0 = stalls_now();
      run_op(2, 0, 1, 7, 6, 1); #1;
      chk("R6", "plain xor waits in rename mode", stalls_now() - s0, 3);
      drain();
      @(negedge clk);
      in_valid = 1'b0;
      #1;
      chk("R9", "idle stall", int'(stall), 0);
      chk("R10", "final issued_cnt", int'(issued_cnt), m_iss);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule